// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This unit tracks which interrupt vectors are waiting and which are being serviced for one processor. It also decides whether a waiting vector may interrupt the current work. It keeps three pieces of state:
- a 256-bit pending bitmap, with one bit per vector;
- a 256-bit in-service bitmap;
- an 8-bit task priority value.

Each cycle, the unit finds the highest pending vector and the highest in-service vector. From the task priority and the in-service priority class it forms a processor priority. A pending vector is offered only when its priority class is strictly above that processor priority.

A requester posts vectors through a set port. Software-visible priority is changed through a task priority write port. The processor core pulses an acknowledge strobe to take the offered vector. That vector then moves from the pending bitmap to the in-service bitmap. An end-of-interrupt strobe retires the highest in-service vector. A 4-bit view of the task priority class is also provided for control-register style access.

Top module: `intr_prio_unit`

## Requirements
- R1: After reset both bitmaps and the task priority are zero, so `has_intr_o`, `ppr_o` and `cr8_o` read 0.
- R2: A set request with vector 16 or above marks that vector pending from the next cycle. A set request with a vector below 16 has no effect. Vectors 0 to 15 are never offered.
- R3: The offered vector `intr_vec_o` is the highest-numbered pending vector, searched over the whole 256-bit bitmap. The search covers each of the eight 32-bit words.
- R4: `ppr_o` equals the task priority when its bits [7:4] are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise `ppr_o` is that vector with bits [3:0] cleared. An empty in-service bitmap counts as vector 0.
- R5: `has_intr_o` is 1 exactly when the unit is enabled, some vector is pending, and (highest pending vector AND 0xF0) is greater than `ppr_o`. An equal priority class blocks delivery.
- R6: An acknowledge while `has_intr_o` is 1 takes the offered vector. From the next cycle that vector is in service and no longer pending, and `ppr_o` reflects the new in-service state. An acknowledge while `has_intr_o` is 0 is ignored.
- R7: An end-of-interrupt clears the highest set in-service bit. The new `ppr_o` is visible in the next cycle.
- R8: A set request and an acknowledge in the same cycle are both applied. The acknowledged vector is taken from the state before that cycle. If both name the same vector, the vector is marked in service and also stays pending.
- R9: `cr8_o` equals bits [7:4] of the task priority, and a task priority write takes effect in the next cycle.
- R10: While `enable_i` is 0, `has_intr_o` is 0 and acknowledges are ignored. Pending state is kept and set requests are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Unit enable; gates delivery |
| set_vld_i | input | 1 | Set request valid |
| set_vec_i | input | 8 | Vector to mark pending |
| tpr_wr_i | input | 1 | Task priority write strobe |
| tpr_data_i | input | 8 | New task priority |
| ack_i | input | 1 | Acknowledge of the offered vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| has_intr_o | output | 1 | A vector may be delivered |
| intr_vec_o | output | 8 | Deliverable vector (0 when none) |
| ppr_o | output | 8 | Current processor priority |
| cr8_o | output | 4 | Task priority class view |

## Verification
The hardest situation to reach from the ports is a blocked delivery at a class boundary. In that case a vector is pending, but its class equals the processor priority class. That priority may come either from the task priority or from an in-service vector that an earlier acknowledge put there. Directed steps build this case deliberately: they post vectors in different words, raise the task priority to the same class and one below it, then acknowledge and retire vectors so that the in-service class gates a lower pending one. Long random runs of mixed set, acknowledge, retire and priority writes are then compared against a bench model on every cycle.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
    localparam int IPU_NUM_VEC = 256;
    localparam int IPU_WORD_W  = 32;
    localparam int IPU_CLS_W   = 4;
    localparam int IPU_MIN_VEC = 16;
endpackage

// File: rtl/intr_vec_search.sv
// Highest-set-bit search over a wide bitmap, done word by word.
module intr_vec_search #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int OFF_W     = $clog2(WORD_W)
) (
    input  logic [NUM_VEC-1:0] bits_i,
    input  logic               gate_i,
    output logic               found_o,
    output logic [VEC_W-1:0]   vec_o
);
    logic [NUM_WORDS-1:0] word_any;
    logic [OFF_W-1:0]     word_off [NUM_WORDS];
    logic                 found_raw;
    logic [VEC_W-1:0]     vec_raw;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_any[w] = |bits_i[w*WORD_W +: WORD_W];
        always_comb begin
            word_off[w] = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits_i[w*WORD_W + b]) word_off[w] = OFF_W'(b);
            end
        end
    end

    // Higher words overwrite lower ones: top word wins.
    always_comb begin
        found_raw = 1'b0;
        vec_raw   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) begin
                found_raw = 1'b1;
                vec_raw   = VEC_W'(w * WORD_W) | VEC_W'(word_off[w]);
            end
        end
    end

    assign found_o = gate_i & found_raw;
    assign vec_o   = found_o ? vec_raw : '0;
endmodule

// File: rtl/intr_prio_gate.sv
// Processor priority and delivery decision.
module intr_prio_gate #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic             enable_i,
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             irr_found_i,
    input  logic [VEC_W-1:0] irr_vec_i,
    input  logic             isr_found_i,
    input  logic [VEC_W-1:0] isr_vec_i,
    output logic [VEC_W-1:0] ppr_o,
    output logic             deliver_o
);
    localparam int SUB_W = VEC_W - CLS_W;

    logic [VEC_W-1:0] isr_eff;
    logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls;

    always_comb begin
        isr_eff = isr_found_i ? isr_vec_i : '0;
        tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
        isr_cls = isr_eff[VEC_W-1 -: CLS_W];
        irr_cls = irr_vec_i[VEC_W-1 -: CLS_W];
        if (tpr_cls >= isr_cls) ppr_o = tpr_i;
        else                    ppr_o = {isr_cls, {SUB_W{1'b0}}};
        deliver_o = enable_i & irr_found_i & ({irr_cls, {SUB_W{1'b0}}} > ppr_o);
    end
endmodule

// File: rtl/intr_prio_unit.sv
module intr_prio_unit
    import intr_prio_pkg::*;
#(
    parameter int NUM_VEC = IPU_NUM_VEC,
    parameter int WORD_W  = IPU_WORD_W,
    parameter int CLS_W   = IPU_CLS_W,
    parameter int MIN_VEC = IPU_MIN_VEC,
    localparam int VEC_W  = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             set_vld_i,
    input  logic [VEC_W-1:0] set_vec_i,
    input  logic             tpr_wr_i,
    input  logic [VEC_W-1:0] tpr_data_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             has_intr_o,
    output logic [VEC_W-1:0] intr_vec_o,
    output logic [VEC_W-1:0] ppr_o,
    output logic [CLS_W-1:0] cr8_o
);
    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [VEC_W-1:0]   tpr;
        logic               pend;
    } ipu_state_t;

    ipu_state_t st_d, st_q;

    logic             irr_found, isr_found, deliver;
    logic [VEC_W-1:0] irr_vec, isr_vec;
    logic             ack_take;

    intr_vec_search #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr_search (
        .bits_i (st_q.irr),
        .gate_i (st_q.pend),
        .found_o(irr_found),
        .vec_o  (irr_vec)
    );

    intr_vec_search #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_search (
        .bits_i (st_q.isr),
        .gate_i (1'b1),
        .found_o(isr_found),
        .vec_o  (isr_vec)
    );

    intr_prio_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
        .enable_i   (enable_i),
        .tpr_i      (st_q.tpr),
        .irr_found_i(irr_found),
        .irr_vec_i  (irr_vec),
        .isr_found_i(isr_found),
        .isr_vec_i  (isr_vec),
        .ppr_o      (ppr_o),
        .deliver_o  (deliver)
    );

    assign ack_take = ack_i & deliver;

    always_comb begin
        st_d = st_q;
        // Retire first, then take: a same-cycle acknowledge sets its bit last.
        if (eoi_i && isr_found) st_d.isr[isr_vec] = 1'b0;
        if (ack_take) begin
            st_d.irr[irr_vec] = 1'b0;
            st_d.isr[irr_vec] = 1'b1;
        end
        // A new request lands after the acknowledge clear, so it survives.
        if (set_vld_i && (set_vec_i >= VEC_W'(MIN_VEC))) st_d.irr[set_vec_i] = 1'b1;
        if (tpr_wr_i) st_d.tpr = tpr_data_i;
        st_d.pend = |st_d.irr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign has_intr_o = deliver;
    assign intr_vec_o = deliver ? irr_vec : '0;
    assign cr8_o      = st_q.tpr[VEC_W-1 -: CLS_W];

    a_r2_low_vec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld_i && set_vec_i < VEC_W'(MIN_VEC))
        |=> st_q.irr[$past(set_vec_i)] == $past(st_q.irr[set_vec_i]));

    a_r2_no_low_offer: assert property (@(posedge clk) disable iff (!rst_n)
        has_intr_o |-> intr_vec_o >= VEC_W'(MIN_VEC));

    a_r3_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        has_intr_o |-> st_q.irr[intr_vec_o]);

    a_r5_class_above_ppr: assert property (@(posedge clk) disable iff (!rst_n)
        has_intr_o |-> intr_vec_o[VEC_W-1 -: CLS_W] > ppr_o[VEC_W-1 -: CLS_W]);

    a_r6_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && has_intr_o && !(set_vld_i && set_vec_i == intr_vec_o))
        |=> st_q.isr[$past(intr_vec_o)] && !st_q.irr[$past(intr_vec_o)]);

    a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && isr_found && !(ack_i && has_intr_o && intr_vec_o == isr_vec))
        |=> !st_q.isr[$past(isr_vec)]);

    a_r9_cr8_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr_i |=> cr8_o == $past(tpr_data_i[VEC_W-1 -: CLS_W]));

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !has_intr_o);
endmodule

// File: tb/test_intr_prio_unit.sv
module test_intr_prio_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, set_vld_i = 1'b0, tpr_wr_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0;
    logic [7:0] set_vec_i = '0, tpr_data_i = '0;
    logic       has_intr_o;
    logic [7:0] intr_vec_o, ppr_o;
    logic [3:0] cr8_o;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [255:0] m_irr = '0, m_isr = '0;
    int           m_tpr = 0;

    always #5 clk = ~clk;

    intr_prio_unit i_intr_prio_unit (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .set_vld_i(set_vld_i), .set_vec_i(set_vec_i),
        .tpr_wr_i(tpr_wr_i), .tpr_data_i(tpr_data_i),
        .ack_i(ack_i), .eoi_i(eoi_i),
        .has_intr_o(has_intr_o), .intr_vec_o(intr_vec_o),
        .ppr_o(ppr_o), .cr8_o(cr8_o)
    );

    function automatic int hi(input logic [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    function automatic int ppr_f(input int tpr, input logic [255:0] isr);
        int h = hi(isr);
        if (h < 0) h = 0;
        if ((tpr & 'hF0) >= (h & 'hF0)) return tpr & 'hFF;
        return h & 'hF0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit en, input bit sv, input int svec, input bit tw,
                       input int td, input bit ak, input bit eo, input string tag);
        int h, p, e;
        bit exp_has;
        @(negedge clk);
        enable_i = en; set_vld_i = sv; set_vec_i = 8'(svec);
        tpr_wr_i = tw; tpr_data_i = 8'(td); ack_i = ak; eoi_i = eo;
        #1;
        h = hi(m_irr);
        p = ppr_f(m_tpr, m_isr);
        exp_has = en && (h >= 0) && ((h & 'hF0) > p);
        chk({tag, " has_intr"}, int'(has_intr_o), int'(exp_has));
        chk({tag, " vector"}, int'(intr_vec_o), exp_has ? h : 0);
        chk({tag, " ppr"}, int'(ppr_o), p);
        chk({tag, " cr8"}, int'(cr8_o), (m_tpr >> 4) & 'hF);
        e = hi(m_isr);
        if (eo && e >= 0) m_isr[e] = 1'b0;
        if (ak && exp_has) begin
            m_irr[h] = 1'b0;
            m_isr[h] = 1'b1;
        end
        if (sv && svec >= 16) m_irr[svec] = 1'b1;
        if (tw) m_tpr = td;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //            en sv vec   tw td    ak eo
        cyc(1, 1, 'h05, 0, 0,    0, 0, "R1 reset state");
        cyc(1, 1, 'h20, 0, 0,    0, 0, "R2 low vector ignored");
        cyc(1, 1, 'h9F, 0, 0,    0, 0, "R3 single pending");
        cyc(1, 1, 'h41, 0, 0,    0, 0, "R3 highest across words");
        cyc(1, 0, 0,    1, 'hA0, 0, 0, "R3 highest of three");
        cyc(1, 0, 0,    1, 'h90, 0, 0, "R4 R9 task priority above");
        cyc(1, 0, 0,    1, 'h8F, 0, 0, "R5 equal class blocks");
        cyc(1, 0, 0,    1, 0,    0, 0, "R5 class just above ppr");
        cyc(1, 0, 0,    0, 0,    1, 0, "R5 R9 priority cleared");
        cyc(1, 0, 0,    0, 0,    0, 1, "R6 R4 acked vector in service");
        cyc(1, 0, 0,    0, 0,    0, 0, "R7 eoi cleared service");
        cyc(0, 0, 0,    0, 0,    1, 0, "R10 disabled quiet");
        cyc(1, 1, 'h41, 0, 0,    1, 0, "R10 ack ignored while disabled");
        cyc(1, 0, 0,    0, 0,    0, 1, "R8 set and ack same vector");
        cyc(1, 1, 'h30, 0, 0,    1, 0, "R8 vector still pending");
        cyc(1, 0, 0,    0, 0,    0, 0, "R8 set beside ack");
        // direct literal checks of the state built above
        chk("R8 literal ppr after ack of 0x41", int'(ppr_o), 'h40);
        chk("R2 literal no low vector", int'(intr_vec_o < 8'd16 && has_intr_o), 0);
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(99, 0));
            cyc(r < 93, $urandom_range(99, 0) < 45, int'($urandom_range(255, 0)),
                $urandom_range(99, 0) < 8, int'($urandom_range(255, 0)),
                $urandom_range(99, 0) < 35, $urandom_range(99, 0) < 28,
                "R3 R4 R5 R6 R7 random");
        end
        cyc(1, 0, 0, 0, 0, 0, 0, "R6 R7 random final");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule